// File: doc/BRIEF.md
# Power-Management Bus Command Front-End

This block is the register-side front end of a serial power-management bus master. Software reaches it over APB. For each channel it writes up to four payload words, then writes a command word. When that word carries the start bit, the channel raises a request to its back end with the decoded command type, target slave, register address, byte count and payload. The back end runs the serial transfer and answers with a one-cycle acknowledge, an error flag and up to sixteen returned bytes. The block records the outcome in a status word owned by the target slave. For read-type commands it also stores the returned bytes in that slave's read-data words.

Every channel owns an independent copy of the register set, and the copies repeat at a fixed address stride. Within a channel, the status word and the read-data words are banked by slave ID, so software can poll the result for one slave without a second decode step. The command word and the payload words are shared by all slaves of the channel. The number of channels and the APB address width are parameters. There are sixteen slave IDs and a 16-byte payload.

Top module: `pm_cmd_apb`

## Requirements
- R1: Channel c has its command word at c*0x300+0x100. The fields are: bit 31 start, bits 27:24 command type, bits 23:20 byte count minus one, bits 19:16 slave ID, bits 15:0 register address. A command write made while the channel is idle stores the fields, and they read back in place. Only when bit 31 is 1 does the write raise the request, with those fields on be_opcode, be_slave, be_len and be_addr.
- R2: Command types 2, 4 and 6 are read types. An acknowledged read-type command stores the returned bytes. The other types (0 zero-write, 1 write, 3 extended write, 5 extended-long write, 7 reset, 8 sleep, 9 shutdown, 10 wakeup) leave the slave's read-data words unchanged.
- R3: The payload words at c*0x300+0x104, +0x108, +0x10C and +0x110 read back as written. They are presented big-endian on be_wdata: payload byte n sits at be_wdata[127-8n -: 8], so word k bits 31:24 carry byte 4k. The payload stays stable while the request is pending.
- R4: While a transaction is in flight, bit 31 of the command word reads 1 and be_req stays high until be_ack. Bit 31 clears in the cycle after be_ack, and be_req falls in the same cycle.
- R5: The status word of slave s is at c*0x300+0x200+0x20*s, with bit 0 done and bit 2 fail. A start clears both bits for the target slave. The acknowledge sets done and copies be_err into fail.
- R6: The read-data word k (k = 0..3) of slave s is at c*0x300+0x204+0x20*s+4k. It holds the returned bytes with the same big-endian packing as R3. Bytes at positions at or beyond the requested count read as zero.
- R7: A command write with bit 31 set, made while the channel is busy, is ignored and asserts pslverr in its access cycle. Payload-word writes made while busy are ignored too. No other write raises pslverr.
- R8: Channels are independent. A transaction on one channel changes no register of another channel.
- R9: pready is always high. Reads of any address that no channel maps return zero.
- R10: After reset, all registers read zero and no request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error for a rejected command |
| be_req | output | NCH | Per-channel transaction request |
| be_opcode | output | 4*NCH | Command type per channel |
| be_slave | output | 4*NCH | Slave ID per channel |
| be_len | output | 4*NCH | Byte count minus one per channel |
| be_addr | output | 16*NCH | Register address per channel |
| be_wdata | output | 128*NCH | Big-endian payload per channel |
| be_ack | input | NCH | One-cycle completion pulse per channel |
| be_err | input | NCH | Failure flag, valid with be_ack |
| be_rdata | input | 128*NCH | Returned bytes, valid with be_ack |

## Verification
A command write takes effect at the clock edge that ends its APB access phase. be_req is high from the next sampling point on. The bench's back end counts a set latency from that point before it pulses be_ack. Status, read data and the cleared start bit are visible one edge after the acknowledge. The bench checks them with APB reads it issues only after a wait longer than that latency, or reads mid-flight on purpose when a long latency is set. Read data and pslverr are combinational in the access phase, so the monitor compares them a quarter period after the access phase is driven. Requests are compared against a queue of expected commands at the first sampling point where be_req is high.

// File: rtl/pm_cmd_pkg.sv
package pm_cmd_pkg;
   localparam int unsigned NSLV      = 16;
   localparam int unsigned NWORD     = 4;
   localparam int unsigned PAYLOAD_W = NWORD * 32;
   localparam int unsigned NBYTE     = PAYLOAD_W / 8;
   localparam int unsigned CH_STRIDE = 'h300;

   typedef enum logic [3:0] {
      OP_ZWR  = 4'd0, OP_WR  = 4'd1, OP_RD   = 4'd2, OP_XWR = 4'd3,
      OP_XRD  = 4'd4, OP_XWRL = 4'd5, OP_XRDL = 4'd6, OP_RST = 4'd7,
      OP_SLP  = 4'd8, OP_SHDN = 4'd9, OP_WAKE = 4'd10
   } op_e;

   typedef struct packed {
      logic [3:0]  opc;
      logic [3:0]  len;
      logic [3:0]  sid;
      logic [15:0] addr;
   } cmd_t;

   function automatic logic is_read(logic [3:0] opc);
      return (opc == OP_RD) || (opc == OP_XRD) || (opc == OP_XRDL);
   endfunction

   function automatic logic [PAYLOAD_W-1:0] keep_mask(logic [3:0] len);
      logic [PAYLOAD_W-1:0] m;
      m = '0;
      for (int i = 0; i < NBYTE; i++)
         if (i <= int'(len)) m[PAYLOAD_W-1-8*i -: 8] = 8'hFF;
      return m;
   endfunction
endpackage

// File: rtl/pm_reg_decode.sv
module pm_reg_decode #(
   parameter int ADDR_W = 16,
   parameter int CH     = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_cmd,
   output logic [3:0]        hit_wd,
   output logic              hit_stat,
   output logic [3:0]        hit_rd,
   output logic [3:0]        sid
);
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH * pm_cmd_pkg::CH_STRIDE);

   logic [ADDR_W-1:0] rel;
   logic              in_slv;

   assign rel     = addr - BASE;
   assign in_slv  = (rel[ADDR_W-1:10] == '0) && rel[9];
   assign sid     = rel[8:5];
   assign hit_cmd = (rel == ADDR_W'('h100));
   assign hit_stat = in_slv && (rel[4:0] == 5'd0);

   for (genvar k = 0; k < 4; k++) begin : g_word
      assign hit_wd[k] = (rel == ADDR_W'('h104 + 4 * k));
      assign hit_rd[k] = in_slv && (rel[4:0] == 5'(4 * (k + 1)));
   end
endmodule

// File: rtl/pm_chan_regs.sv
module pm_chan_regs
   import pm_cmd_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CH     = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wr,
   input  logic [31:0]          wdata,
   output logic [31:0]          rdata,
   output logic                 cmd_reject,
   output logic                 be_req,
   output logic [3:0]           be_opcode,
   output logic [3:0]           be_slave,
   output logic [3:0]           be_len,
   output logic [15:0]          be_addr,
   output logic [PAYLOAD_W-1:0] be_wdata,
   input  logic                 be_ack,
   input  logic                 be_err,
   input  logic [PAYLOAD_W-1:0] be_rdata
);
   logic       hit_cmd, hit_stat;
   logic [3:0] hit_wd, hit_rd, sid;

   pm_reg_decode #(.ADDR_W(ADDR_W), .CH(CH)) u_dec (
      .addr(addr), .hit_cmd(hit_cmd), .hit_wd(hit_wd), .hit_stat(hit_stat),
      .hit_rd(hit_rd), .sid(sid)
   );

   logic                 busy;
   cmd_t                 cmd_q, cmd_in;
   logic [31:0]          wd_q [NWORD];
   logic [NSLV-1:0]      done_q, fail_q;
   logic [PAYLOAD_W-1:0] rd_q [NSLV];
   logic                 wr_cmd, start, finish;

   assign cmd_in     = cmd_t'(wdata[27:0]);
   assign wr_cmd     = wr && hit_cmd;
   assign start      = wr_cmd && wdata[31] && !busy;
   assign cmd_reject = wr_cmd && wdata[31] && busy;
   assign finish     = busy && be_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cmd_q <= '0;
         for (int k = 0; k < NWORD; k++) wd_q[k] <= '0;
      end else begin
         if (start) busy <= 1'b1;
         else if (finish) busy <= 1'b0;
         if (wr_cmd && !busy) cmd_q <= cmd_in;
         for (int k = 0; k < NWORD; k++)
            if (wr && hit_wd[k] && !busy) wd_q[k] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= '0;
         fail_q <= '0;
         for (int s = 0; s < NSLV; s++) rd_q[s] <= '0;
      end else if (start) begin
         done_q[cmd_in.sid] <= 1'b0;
         fail_q[cmd_in.sid] <= 1'b0;
      end else if (finish) begin
         done_q[cmd_q.sid] <= 1'b1;
         fail_q[cmd_q.sid] <= be_err;
         if (is_read(cmd_q.opc))
            rd_q[cmd_q.sid] <= be_rdata & keep_mask(cmd_q.len);
      end
   end

   assign be_req    = busy;
   assign be_opcode = cmd_q.opc;
   assign be_slave  = cmd_q.sid;
   assign be_len    = cmd_q.len;
   assign be_addr   = cmd_q.addr;
   assign be_wdata  = {wd_q[0], wd_q[1], wd_q[2], wd_q[3]};

   always_comb begin
      rdata = '0;
      if (hit_cmd)  rdata = {busy, 3'b000, cmd_q};
      if (hit_stat) rdata = {29'd0, fail_q[sid], 1'b0, done_q[sid]};
      for (int k = 0; k < NWORD; k++) begin
         if (hit_wd[k]) rdata = wd_q[k];
         if (hit_rd[k]) rdata = rd_q[sid][PAYLOAD_W-1-32*k -: 32];
      end
   end
endmodule

// File: rtl/pm_cmd_apb.sv
module pm_cmd_apb
   import pm_cmd_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int ADDR_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     psel,
   input  logic                     penable,
   input  logic                     pwrite,
   input  logic [ADDR_W-1:0]        paddr,
   input  logic [31:0]              pwdata,
   output logic [31:0]              prdata,
   output logic                     pready,
   output logic                     pslverr,
   output logic [NCH-1:0]           be_req,
   output logic [4*NCH-1:0]         be_opcode,
   output logic [4*NCH-1:0]         be_slave,
   output logic [4*NCH-1:0]         be_len,
   output logic [16*NCH-1:0]        be_addr,
   output logic [PAYLOAD_W*NCH-1:0] be_wdata,
   input  logic [NCH-1:0]           be_ack,
   input  logic [NCH-1:0]           be_err,
   input  logic [PAYLOAD_W*NCH-1:0] be_rdata
);
   localparam int SPAN = (NCH - 1) * CH_STRIDE + 'h400;

   if (NCH < 1) begin : g_bad_nch
      $error("pm_cmd_apb: NCH must be at least 1");
   end
   if (ADDR_W < 11 || ADDR_W > 31 || (ADDR_W < 31 && SPAN > (1 << ADDR_W))) begin : g_bad_aw
      $error("pm_cmd_apb: ADDR_W cannot hold the channel map");
   end

   logic            wr;
   logic [31:0]     ch_rdata [NCH];
   logic [NCH-1:0]  ch_reject;

   assign wr     = psel && penable && pwrite;
   assign pready = 1'b1;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      pm_chan_regs #(.ADDR_W(ADDR_W), .CH(c)) u_chan (
         .clk(clk), .rst_n(rst_n), .addr(paddr), .wr(wr), .wdata(pwdata),
         .rdata(ch_rdata[c]), .cmd_reject(ch_reject[c]),
         .be_req(be_req[c]),
         .be_opcode(be_opcode[4*c +: 4]), .be_slave(be_slave[4*c +: 4]),
         .be_len(be_len[4*c +: 4]), .be_addr(be_addr[16*c +: 16]),
         .be_wdata(be_wdata[PAYLOAD_W*c +: PAYLOAD_W]),
         .be_ack(be_ack[c]), .be_err(be_err[c]),
         .be_rdata(be_rdata[PAYLOAD_W*c +: PAYLOAD_W])
      );
   end

   always_comb begin
      prdata = '0;
      if (psel && !pwrite)
         for (int c = 0; c < NCH; c++) prdata = prdata | ch_rdata[c];
   end

   assign pslverr = |ch_reject;
endmodule

// File: rtl/pm_cmd_apb_chk.sv
module pm_cmd_apb_chk #(
   parameter int NCH    = 4,
   parameter int ADDR_W = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 psel,
   input logic                 penable,
   input logic                 pwrite,
   input logic [31:0]          pwdata,
   input logic                 pslverr,
   input logic [NCH-1:0]       be_req,
   input logic [NCH-1:0]       be_ack,
   input logic [4*NCH-1:0]     be_opcode,
   input logic [16*NCH-1:0]    be_addr,
   input logic [128*NCH-1:0]   be_wdata
);
   assert_reject_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pslverr |-> (psel && penable && pwrite && pwdata[31]));

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (be_req[c] && !be_ack[c]) |=> be_req[c]);

      assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (be_req[c] && be_ack[c]) |=> !be_req[c]);

      assert_req_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(be_req[c]) |-> $past(psel && penable && pwrite && pwdata[31]));

      assert_payload_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (be_req[c] && !be_ack[c]) |=>
            ($stable(be_wdata[128*c +: 128]) && $stable(be_opcode[4*c +: 4])
             && $stable(be_addr[16*c +: 16])));
   end
endmodule

bind pm_cmd_apb pm_cmd_apb_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
   .pwdata(pwdata), .pslverr(pslverr), .be_req(be_req), .be_ack(be_ack),
   .be_opcode(be_opcode), .be_addr(be_addr), .be_wdata(be_wdata)
);

// File: tb/tb_pm_cmd_apb.sv
module tb_pm_cmd_apb;
   localparam int NCH = 4;
   localparam int AW  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [AW-1:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic pready, pslverr;
   logic [NCH-1:0] be_req;
   logic [4*NCH-1:0] be_opcode, be_slave, be_len;
   logic [16*NCH-1:0] be_addr;
   logic [128*NCH-1:0] be_wdata;
   logic [NCH-1:0] be_ack = '0, be_err = '0;
   logic [128*NCH-1:0] be_rdata = '0;

   always #10 clk = ~clk;

   pm_cmd_apb #(.NCH(NCH), .ADDR_W(AW)) dut (.*);

   int checks = 0, errors = 0;
   bit finished = 0;

   typedef struct {
      int ch; logic [3:0] opc, sid, len; logic [15:0] addr; logic [127:0] wd; string tag;
   } req_t;

   req_t        req_q[$];
   logic [31:0] rd_q[$];
   string       rd_tag_q[$];
   bit          err_q[$];

   logic [127:0] resp_data [NCH];
   bit           resp_err  [NCH];
   int           lat       [NCH];
   int           cnt       [NCH];
   logic [NCH-1:0] req_prev = '0;

   task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // back-end model
   always @(negedge clk) begin
      for (int c = 0; c < NCH; c++) begin
         if (be_req[c] && !be_ack[c]) begin
            if (cnt[c] >= lat[c]) begin
               be_ack[c] = 1'b1;
               be_err[c] = resp_err[c];
               be_rdata[128*c +: 128] = resp_data[c];
            end else cnt[c]++;
         end else begin
            be_ack[c] = 1'b0;
            cnt[c] = 0;
         end
      end
   end

   // monitor
   always @(negedge clk) begin
      #5;
      if (psel && penable && !pwrite) begin
         if (rd_q.size() == 0) chk(0, "read-queue-empty", prdata, 0);
         else begin
            logic [31:0] e; string t;
            e = rd_q.pop_front(); t = rd_tag_q.pop_front();
            chk(prdata === e, t, prdata, e);
         end
      end
      if (psel && penable && pwrite) begin
         if (err_q.size() == 0) chk(0, "write-queue-empty", pslverr, 0);
         else begin
            bit e;
            e = err_q.pop_front();
            chk(pslverr === e, "R7 pslverr", pslverr, e);
         end
      end
      for (int c = 0; c < NCH; c++) begin
         if (rst_n && be_req[c] && !req_prev[c]) begin
            if (req_q.size() == 0) chk(0, "R1 unexpected request", c, 0);
            else begin
               req_t r;
               r = req_q.pop_front();
               chk(r.ch == c, {r.tag, " R8 channel"}, c, r.ch);
               chk(be_opcode[4*c +: 4] === r.opc, {r.tag, " R1 opcode"}, be_opcode[4*c +: 4], r.opc);
               chk(be_slave[4*c +: 4] === r.sid, {r.tag, " R1 slave"}, be_slave[4*c +: 4], r.sid);
               chk(be_len[4*c +: 4] === r.len, {r.tag, " R1 len"}, be_len[4*c +: 4], r.len);
               chk(be_addr[16*c +: 16] === r.addr, {r.tag, " R1 addr"}, be_addr[16*c +: 16], r.addr);
               chk(be_wdata[128*c +: 128] === r.wd, {r.tag, " R3 payload"}, be_wdata[128*c +: 128], r.wd);
            end
         end
      end
      req_prev = be_req;
   end

   task automatic apb_write(logic [AW-1:0] a, logic [31:0] d, bit exp_err);
      err_q.push_back(exp_err);
      @(negedge clk);
      psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1;
      @(negedge clk);
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic apb_read(logic [AW-1:0] a, logic [31:0] e, string tag);
      rd_q.push_back(e); rd_tag_q.push_back(tag);
      @(negedge clk);
      psel = 1; pwrite = 0; penable = 0; paddr = a;
      @(negedge clk);
      penable = 1;
      @(negedge clk);
      psel = 0; penable = 0;
   endtask

   function automatic logic [AW-1:0] base(int c);
      return AW'(c * 'h300);
   endfunction

   task automatic start_cmd(int c, logic [3:0] opc, logic [3:0] sid, logic [15:0] a,
                            int nbytes, logic [127:0] wd, string tag);
      req_t r;
      r.ch = c; r.opc = opc; r.sid = sid; r.len = 4'(nbytes - 1); r.addr = a; r.wd = wd; r.tag = tag;
      req_q.push_back(r);
      apb_write(base(c) + 16'h100, {1'b1, 3'b000, opc, 4'(nbytes - 1), sid, a}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   logic [127:0] seq;

   initial begin
      for (int c = 0; c < NCH; c++) begin
         resp_data[c] = '0; resp_err[c] = 0; lat[c] = 3; cnt[c] = 0;
      end
      for (int i = 0; i < 16; i++) seq[127-8*i -: 8] = 8'(8'h10 + i);
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R10 reset state
      chk(be_req === '0, "R10 no request after reset", be_req, 0);
      apb_read(16'h100, 0, "R10 command word");
      apb_read(16'h200, 0, "R10 status");
      apb_read(16'h204, 0, "R10 read data");
      apb_read(16'h104, 0, "R10 payload word");

      // R1/R3 register write, 5 bytes, slave 3
      apb_write(16'h104, 32'hA1B2C3D4, 0);
      apb_write(16'h108, 32'hE5000000, 0);
      apb_read(16'h108, 32'hE5000000, "R3 payload readback");
      start_cmd(0, 4'd1, 4'd3, 16'h1234, 5, {32'hA1B2C3D4, 32'hE5000000, 64'd0}, "T1");
      repeat (12) @(negedge clk);
      apb_read(16'h100, 32'h0143_1234, "R1 fields readback, start cleared");
      apb_read(16'h260, 32'h1, "R5 done slave 3");
      apb_read(16'h264, 32'h0, "R2 write type leaves read data");

      // R1 command without start bit: stored, no request
      apb_write(16'h100, 32'h0209_0002, 0);
      repeat (10) @(negedge clk);
      apb_read(16'h100, 32'h0209_0002, "R1 no-start write stored");

      // R6 read of 6 bytes, slave 5
      resp_data[0] = seq; resp_err[0] = 0;
      start_cmd(0, 4'd2, 4'd5, 16'h0040, 6, {32'hA1B2C3D4, 32'hE5000000, 64'd0}, "T2");
      repeat (12) @(negedge clk);
      apb_read(16'h2A0, 32'h1, "R5 done slave 5");
      apb_read(16'h2A4, 32'h10111213, "R6 word0");
      apb_read(16'h2A8, 32'h14150000, "R6 word1 zero fill");
      apb_read(16'h2AC, 32'h0, "R6 word2 zero");
      apb_read(16'h2B0, 32'h0, "R6 word3 zero");

      // R5/R6 long read of 16 bytes, slave 15, with failure
      resp_err[0] = 1;
      start_cmd(0, 4'd6, 4'd15, 16'hBEEF, 16, {32'hA1B2C3D4, 32'hE5000000, 64'd0}, "T3");
      repeat (12) @(negedge clk);
      apb_read(16'h3E0, 32'h5, "R5 done and fail slave 15");
      apb_read(16'h3EC, 32'h18191A1B, "R6 slave 15 word2");
      apb_read(16'h3F0, 32'h1C1D1E1F, "R6 slave 15 word3");

      // R2 zero-write and reset to slave 5 leave its read data
      resp_data[0] = '1; resp_err[0] = 0;
      start_cmd(0, 4'd0, 4'd5, 16'h0001, 1, {32'hA1B2C3D4, 32'hE5000000, 64'd0}, "T4a");
      repeat (12) @(negedge clk);
      start_cmd(0, 4'd7, 4'd5, 16'h0002, 1, {32'hA1B2C3D4, 32'hE5000000, 64'd0}, "T4b");
      repeat (12) @(negedge clk);
      apb_read(16'h2A4, 32'h10111213, "R2 non-read types keep word0");
      apb_read(16'h2A0, 32'h1, "R5 done after reset type");

      // R4/R5/R7 busy behaviour
      lat[0] = 30;
      start_cmd(0, 4'd1, 4'd3, 16'h0010, 1, {32'hA1B2C3D4, 32'hE5000000, 64'd0}, "T5");
      apb_read(16'h260, 32'h0, "R5 start clears done");
      apb_read(16'h100, 32'h8103_0010, "R4 start bit reads 1 in flight");
      apb_write(16'h100, 32'h8207_0000, 1);
      apb_write(16'h104, 32'hDEADBEEF, 0);
      apb_read(16'h100, 32'h8103_0010, "R7 rejected command ignored");
      apb_read(16'h104, 32'hA1B2C3D4, "R7 payload write ignored while busy");
      repeat (40) @(negedge clk);
      apb_read(16'h100, 32'h0103_0010, "R4 start bit self-clears");
      apb_read(16'h260, 32'h1, "R5 done after long transfer");
      lat[0] = 3;

      // R8 channel 1 independent
      resp_err[1] = 1;
      apb_write(base(1) + 16'h104, 32'h11223344, 0);
      start_cmd(1, 4'd3, 4'd3, 16'h00AA, 4, {32'h11223344, 96'd0}, "T6");
      repeat (12) @(negedge clk);
      apb_read(base(1) + 16'h260, 32'h5, "R8 channel 1 status");
      apb_read(16'h260, 32'h1, "R8 channel 0 untouched");
      apb_read(16'h104, 32'hA1B2C3D4, "R8 channel 0 payload untouched");
      apb_read(base(3) + 16'h260, 32'h0, "R8 channel 3 untouched");

      // R9 unmapped
      apb_read(16'h0000, 32'h0, "R9 unmapped 0x000");
      apb_read(16'h00FC, 32'h0, "R9 unmapped 0x0FC");
      apb_read(16'h0114, 32'h0, "R9 unmapped 0x114");
      apb_read(16'h03F4, 32'h0, "R9 unmapped 0x3F4");
      apb_read(16'h0D00, 32'h0, "R9 beyond last channel");
      chk(pready === 1'b1, "R9 pready", pready, 1);

      repeat (5) @(negedge clk);
      chk(req_q.size() == 0, "R1 all requests seen", req_q.size(), 0);
      chk(rd_q.size() == 0, "reads all checked", rd_q.size(), 0);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule